// File: doc/BRIEF.md
# Lamp Ballast Start-Up Sequencer

This block controls the two gate signals of a half-bridge that drives a fluorescent lamp. Once the supply word shows a valid level, it starts a sequence. First comes a heating phase at a high switching frequency for a programmed number of switching periods. Next comes a ramp that moves the frequency linearly down to the run value over one tenth of that number of periods. Last comes steady running at the run frequency with a 50% duty cycle. A phase accumulator (NCO) sets the frequency. Its most significant bit picks which gate may conduct. A fixed dead time keeps both gates low after every change of polarity.

The block has two protection inputs. The fault input puts the block into a latched shutdown: both gates go low and the accumulator stops. Only two things clear this latch. One is a drop of the supply below the lower threshold. The other is a rising edge on the restart input, which also starts the whole sequence again from the first heating period. The supply check has hysteresis: the block starts above an upper level and stops below a lower level. Phase changes and frequency updates wait for the accumulator to wrap, so no switching period is cut short.

Top module: `ballast_seq`

## Requirements
- R1: While reset is held, and after it is released, both gates are low and `phase_st` reads 0. Until the supply is valid, `phase_st` keeps reading 0. The encoding of `phase_st` is: 0 off, 1 heating, 2 ramp, 3 running.
- R2: The supply becomes valid when `supply_lvl` >= UV_ON and invalid when it is < UV_OFF. A level between the two keeps the previous state. A change takes effect on `phase_st` two clock edges after the edge that samples it. An invalid supply forces phase 0.
- R3: During heating, the accumulator advances by the captured heating increment on every clock. The heating phase lasts exactly `preheat_len` accumulator wraps. A value of 0 counts as 1. With 16-bit phase and an increment of 4096, the period is 16 clocks and 20 periods take 320 clocks.
- R4: The ramp lasts floor(`preheat_len`/10) wraps. Ramp period p (counted from 0) uses the increment inc_pre − floor((inc_pre − inc_run)·(p+1)/N), where N is the ramp length. So the last ramp period already runs at the run increment. When N is 0 the ramp is skipped and heating goes straight to running.
- R5: While running, the run increment is used. The high gate may be on while the accumulator MSB is 1 and the low gate while it is 0, so both gates get equal on-times.
- R6: The two gates are never high together. After every flip of the accumulator MSB, both gates stay low for exactly DEAD_CYC clocks.
- R7: When `fault_en` is high, three edges later both gates are low and `phase_st` is 0. This state is held after `fault_en` returns low.
- R8: The fault latch clears on a rising edge of `restart_en` while the supply is valid, or when the supply falls below UV_OFF.
- R9: A rising edge of `restart_en` in any phase restarts the sequence at the first heating period with the accumulator at zero.
- R10: A pulse of a single clock period on `fault_en` or `restart_en` is recognised.
- R11: A phase change between heating, ramp and running happens, and the increment changes, only on a clock edge where the accumulator wraps. The increments and the heating length are captured when a sequence starts, and later changes to those inputs have no effect on the running sequence.
- R12: An invalid supply takes priority over the fault input, and the fault input takes priority over restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_lvl | input | SUP_W | Digitised supply level |
| fault_en | input | 1 | Fault input, sets the latched shutdown |
| restart_en | input | 1 | Restart input, acts on its rising edge |
| preheat_len | input | TIME_W | Heating length in switching periods |
| inc_pre | input | PHASE_W | Accumulator increment for heating |
| inc_run | input | PHASE_W | Accumulator increment for running |
| gate_hi | output | 1 | High-side gate |
| gate_lo | output | 1 | Low-side gate |
| phase_st | output | 2 | Current phase: 0 off, 1 heating, 2 ramp, 3 running |

## Verification
Each result is due a fixed number of edges after its stimulus:
- A supply change reaches `phase_st` after two edges.
- An enable pulse acts after three edges: two for synchronisation and one for the state register.
- A gate comes on exactly DEAD_CYC edges after the MSB flip that turned the other gate off.
- A new frequency or phase appears on the edge of an accumulator wrap.

A reference model in the bench applies these same latencies on every rising edge, and the outputs are compared on the falling edge. The directed checks wait a number of cycles beyond each latency, or count cycles between gate edges, to measure periods, dead gaps and the heating length.

// File: rtl/ballast_pkg.sv
package ballast_pkg;

  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_HEAT  = 2'd1,
    PH_RAMP  = 2'd2,
    PH_RUN   = 2'd3
  } phase_e;

  // Ramp length in switching periods: one tenth of the heating length.
  function automatic logic [31:0] ramp_periods(input logic [31:0] heat_len);
    return heat_len / 32'd10;
  endfunction

  // Linear interpolation from the heating increment toward the run increment.
  // step runs 1..span; step == span yields the run increment.
  function automatic logic [31:0] ramp_inc(input logic [31:0] from_inc,
                                           input logic [31:0] to_inc,
                                           input logic [31:0] step,
                                           input logic [31:0] span);
    logic [31:0] gap;
    logic [63:0] prod;
    if (span == 32'd0) return to_inc;
    gap  = (from_inc > to_inc) ? (from_inc - to_inc) : 32'd0;
    prod = 64'(gap) * 64'(step);
    return from_inc - 32'(prod / 64'(span));
  endfunction

endpackage

// File: rtl/bal_sync.sv
module bal_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/bal_uvlo.sv
module bal_uvlo #(
  parameter int SUP_W  = 8,
  parameter int UV_ON  = 102,
  parameter int UV_OFF = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUP_W-1:0] supply,
  output logic             uv_ok
);

  localparam logic [SUP_W-1:0] ON_LVL  = SUP_W'(UV_ON);
  localparam logic [SUP_W-1:0] OFF_LVL = SUP_W'(UV_OFF);

  logic above_on, below_off;
  assign above_on  = (supply >= ON_LVL);
  assign below_off = (supply < OFF_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         uv_ok <= 1'b0;
    else if (above_on)  uv_ok <= 1'b1;
    else if (below_off) uv_ok <= 1'b0;
  end

endmodule

// File: rtl/bal_nco_gate.sv
module bal_nco_gate #(
  parameter int PHASE_W  = 16,
  parameter int DEAD_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               start,
  input  logic [PHASE_W-1:0] inc,
  output logic               wrap,
  output logic               msb_flip,
  output logic               gate_hi,
  output logic               gate_lo
);

  localparam int DW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_LD = DW'(DEAD_CYC);

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W:0]   sum;
  logic [DW-1:0]      dz_q;
  logic               gap_done;

  assign sum      = {1'b0, acc_q} + {1'b0, inc};
  assign wrap     = active & sum[PHASE_W];
  assign msb_flip = active & (sum[PHASE_W-1] != acc_q[PHASE_W-1]);
  assign gap_done = (dz_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      dz_q  <= DEAD_LD;
    end else if (!active || start) begin
      acc_q <= '0;
      dz_q  <= DEAD_LD;
    end else begin
      acc_q <= sum[PHASE_W-1:0];
      if (msb_flip)       dz_q <= DEAD_LD;
      else if (!gap_done) dz_q <= dz_q - DW'(1);
    end
  end

  assign gate_hi = active &  acc_q[PHASE_W-1] & gap_done;
  assign gate_lo = active & ~acc_q[PHASE_W-1] & gap_done;

endmodule

// File: rtl/bal_phase_ctl.sv
module bal_phase_ctl
  import ballast_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int TIME_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               uv_ok,
  input  logic               fault_s,
  input  logic               restart_rise,
  input  logic               wrap,
  input  logic [TIME_W-1:0]  heat_len,
  input  logic [PHASE_W-1:0] heat_inc,
  input  logic [PHASE_W-1:0] run_inc,
  output logic [1:0]         phase_o,
  output logic               active,
  output logic               start_evt,
  output logic               halted,
  output logic [PHASE_W-1:0] inc_q,
  output logic [PHASE_W-1:0] heat_inc_q,
  output logic [PHASE_W-1:0] run_inc_q
);

  phase_e            ph_q;
  logic [TIME_W-1:0] cnt_q, heat_len_q, ramp_len_q;
  logic [TIME_W:0]   cnt_inc;
  logic              heat_done, ramp_done;
  logic [PHASE_W-1:0] first_ramp_inc, next_ramp_inc;

  assign cnt_inc   = {1'b0, cnt_q} + {{TIME_W{1'b0}}, 1'b1};
  assign heat_done = (cnt_inc >= {1'b0, heat_len_q});
  assign ramp_done = (cnt_inc >= {1'b0, ramp_len_q});
  assign active    = (ph_q != PH_OFF);
  assign start_evt = uv_ok & ~fault_s & (restart_rise | ((ph_q == PH_OFF) & ~halted));

  assign first_ramp_inc = PHASE_W'(ramp_inc(32'(heat_inc_q), 32'(run_inc_q),
                                            32'd1, 32'(ramp_len_q)));
  assign next_ramp_inc  = PHASE_W'(ramp_inc(32'(heat_inc_q), 32'(run_inc_q),
                                            32'(cnt_q) + 32'd2, 32'(ramp_len_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_OFF;
      halted     <= 1'b0;
      cnt_q      <= '0;
      heat_len_q <= '0;
      ramp_len_q <= '0;
      heat_inc_q <= '0;
      run_inc_q  <= '0;
      inc_q      <= '0;
    end else if (!uv_ok) begin
      ph_q   <= PH_OFF;
      halted <= 1'b0;
    end else if (fault_s) begin
      ph_q   <= PH_OFF;
      halted <= 1'b1;
    end else if (start_evt) begin
      ph_q       <= PH_HEAT;
      halted     <= 1'b0;
      cnt_q      <= '0;
      heat_len_q <= heat_len;
      ramp_len_q <= TIME_W'(ramp_periods(32'(heat_len)));
      heat_inc_q <= heat_inc;
      run_inc_q  <= run_inc;
      inc_q      <= heat_inc;
    end else if (wrap) begin
      case (ph_q)
        PH_HEAT: begin
          if (heat_done) begin
            cnt_q <= '0;
            if (ramp_len_q != '0) begin
              ph_q  <= PH_RAMP;
              inc_q <= first_ramp_inc;
            end else begin
              ph_q  <= PH_RUN;
              inc_q <= run_inc_q;
            end
          end else begin
            cnt_q <= cnt_inc[TIME_W-1:0];
          end
        end
        PH_RAMP: begin
          if (ramp_done) begin
            ph_q  <= PH_RUN;
            cnt_q <= '0;
            inc_q <= run_inc_q;
          end else begin
            cnt_q <= cnt_inc[TIME_W-1:0];
            inc_q <= next_ramp_inc;
          end
        end
        default: ;
      endcase
    end
  end

  assign phase_o = ph_q;

endmodule

// File: rtl/ballast_seq.sv
module ballast_seq #(
  parameter int PHASE_W     = 16,
  parameter int TIME_W      = 16,
  parameter int SUP_W       = 8,
  parameter int DEAD_CYC    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int UV_ON       = 102,
  parameter int UV_OFF      = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SUP_W-1:0]   supply_lvl,
  input  logic               fault_en,
  input  logic               restart_en,
  input  logic [TIME_W-1:0]  preheat_len,
  input  logic [PHASE_W-1:0] inc_pre,
  input  logic [PHASE_W-1:0] inc_run,
  output logic               gate_hi,
  output logic               gate_lo,
  output logic [1:0]         phase_st
);

  logic [1:0]         sync_d, sync_q;
  logic               fault_s, restart_s, restart_prev, restart_rise;
  logic               uv_ok, active, start_evt, fault_latched;
  logic               wrap_evt, msb_flip;
  logic [PHASE_W-1:0] inc_q, inc_pre_q, inc_run_q;

  assign sync_d = {restart_en, fault_en};

  bal_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_d), .q(sync_q)
  );

  assign fault_s   = sync_q[0];
  assign restart_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restart_prev <= 1'b0;
    else        restart_prev <= restart_s;
  end

  assign restart_rise = restart_s & ~restart_prev;

  bal_uvlo #(.SUP_W(SUP_W), .UV_ON(UV_ON), .UV_OFF(UV_OFF)) u_uvlo (
    .clk(clk), .rst_n(rst_n), .supply(supply_lvl), .uv_ok(uv_ok)
  );

  bal_phase_ctl #(.PHASE_W(PHASE_W), .TIME_W(TIME_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .fault_s(fault_s),
    .restart_rise(restart_rise), .wrap(wrap_evt), .heat_len(preheat_len),
    .heat_inc(inc_pre), .run_inc(inc_run), .phase_o(phase_st),
    .active(active), .start_evt(start_evt), .halted(fault_latched),
    .inc_q(inc_q), .heat_inc_q(inc_pre_q), .run_inc_q(inc_run_q)
  );

  bal_nco_gate #(.PHASE_W(PHASE_W), .DEAD_CYC(DEAD_CYC)) u_nco (
    .clk(clk), .rst_n(rst_n), .active(active), .start(start_evt),
    .inc(inc_q), .wrap(wrap_evt), .msb_flip(msb_flip),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

endmodule

// File: rtl/ballast_seq_chk.sv
module ballast_seq_chk #(
  parameter int PHASE_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               gate_hi,
  input logic               gate_lo,
  input logic [1:0]         phase_st,
  input logic               wrap_evt,
  input logic               start_evt,
  input logic               uv_ok,
  input logic               fault_latched,
  input logic [PHASE_W-1:0] inc_q,
  input logic [PHASE_W-1:0] inc_pre_q,
  input logic [PHASE_W-1:0] inc_run_q
);

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  assert_lo_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> !$past(gate_hi));

  assert_hi_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> !$past(gate_lo));

  assert_phase_at_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_st) != 2'd0 && phase_st != 2'd0 && phase_st != 2'd1 &&
     phase_st != $past(phase_st)) |-> $past(wrap_evt));

  assert_inc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_st != 2'd0 && !$past(wrap_evt) && !$past(start_evt)) |-> $stable(inc_q));

  assert_latched_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> (!gate_hi && !gate_lo));

  assert_uv_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_ok |=> (phase_st == 2'd0));

  assert_ramp_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_st == 2'd2 && inc_pre_q > inc_run_q) |->
      (inc_q <= inc_pre_q && inc_q >= inc_run_q));

endmodule

bind ballast_seq ballast_seq_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_hi(gate_hi), .gate_lo(gate_lo),
  .phase_st(phase_st), .wrap_evt(wrap_evt), .start_evt(start_evt),
  .uv_ok(uv_ok), .fault_latched(fault_latched), .inc_q(inc_q),
  .inc_pre_q(inc_pre_q), .inc_run_q(inc_run_q)
);

// File: tb/ballast_seq_tb.sv
module ballast_seq_tb;

  localparam int     PW   = 16;
  localparam int     DEAD = 3;
  localparam longint MOD  = 64'd1 << PW;
  localparam longint HALF = MOD / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  supply_lvl = 8'd0;
  logic        fault_en = 1'b0;
  logic        restart_en = 1'b0;
  logic [15:0] preheat_len = 16'd20;
  logic [15:0] inc_pre = 16'd4096;
  logic [15:0] inc_run = 16'd2048;
  logic        gate_hi, gate_lo;
  logic [1:0]  phase_st;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string cur_req = "R1";

  ballast_seq u_dut (
    .clk(clk), .rst_n(rst_n), .supply_lvl(supply_lvl), .fault_en(fault_en),
    .restart_en(restart_en), .preheat_len(preheat_len), .inc_pre(inc_pre),
    .inc_run(inc_run), .gate_hi(gate_hi), .gate_lo(gate_lo), .phase_st(phase_st)
  );

  always #5 clk = ~clk;

  // reference model state
  longint m_acc, m_inc, m_dz, m_cnt, m_plen, m_slen, m_pinc, m_rinc;
  int     m_ph;
  bit     m_halt, m_uv, m_f1, m_f2, m_r1, m_r2, m_rprev;

  function automatic longint bench_ramp(longint k);
    longint gap;
    gap = (m_pinc > m_rinc) ? (m_pinc - m_rinc) : 0;
    return m_pinc - (gap * k) / m_slen;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_inc = 0; m_dz = DEAD; m_cnt = 0; m_plen = 0; m_slen = 0;
      m_pinc = 0; m_rinc = 0; m_ph = 0; m_halt = 0; m_uv = 0;
      m_f1 = 0; m_f2 = 0; m_r1 = 0; m_r2 = 0; m_rprev = 0;
    end else begin : model_step
      longint sum;
      bit act, wr, fl, rise, st;
      act  = (m_ph != 0);
      sum  = m_acc + m_inc;
      wr   = act && (sum >= MOD);
      fl   = act && (((sum % MOD) >= HALF) != (m_acc >= HALF));
      rise = m_r2 && !m_rprev;
      st   = m_uv && !m_f2 && (rise || (m_ph == 0 && !m_halt));
      if (!act || st) begin
        m_acc = 0; m_dz = DEAD;
      end else begin
        m_acc = sum % MOD;
        if (fl) m_dz = DEAD;
        else if (m_dz > 0) m_dz = m_dz - 1;
      end
      if (!m_uv) begin
        m_ph = 0; m_halt = 0;
      end else if (m_f2) begin
        m_ph = 0; m_halt = 1;
      end else if (st) begin
        m_ph = 1; m_halt = 0; m_cnt = 0;
        m_plen = preheat_len; m_slen = preheat_len / 10;
        m_pinc = inc_pre; m_rinc = inc_run; m_inc = inc_pre;
      end else if (wr) begin
        if (m_ph == 1) begin
          if (m_cnt + 1 >= m_plen) begin
            m_cnt = 0;
            if (m_slen > 0) begin m_ph = 2; m_inc = bench_ramp(1); end
            else begin m_ph = 3; m_inc = m_rinc; end
          end else m_cnt = m_cnt + 1;
        end else if (m_ph == 2) begin
          if (m_cnt + 1 >= m_slen) begin
            m_ph = 3; m_cnt = 0; m_inc = m_rinc;
          end else begin
            m_cnt = m_cnt + 1; m_inc = bench_ramp(m_cnt + 1);
          end
        end
      end
      if (supply_lvl >= 8'd102) m_uv = 1;
      else if (supply_lvl < 8'd80) m_uv = 0;
      m_rprev = m_r2; m_r2 = m_r1; m_r1 = restart_en;
      m_f2 = m_f1; m_f1 = fault_en;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin : cmp
      bit e_hi, e_lo;
      e_hi = (m_ph != 0) && (m_acc >= HALF) && (m_dz == 0);
      e_lo = (m_ph != 0) && (m_acc < HALF) && (m_dz == 0);
      check(gate_hi == e_hi, cur_req, "gate_hi vs model", gate_hi, e_hi);
      check(gate_lo == e_lo, cur_req, "gate_lo vs model", gate_lo, e_lo);
      check(phase_st == m_ph[1:0], cur_req, "phase vs model", phase_st, m_ph);
    end
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired, all requirements, actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_fault();
    fault_en = 1'b1; @(negedge clk); fault_en = 1'b0;
  endtask

  task automatic pulse_restart();
    restart_en = 1'b1; @(negedge clk); restart_en = 1'b0;
  endtask

  task automatic wait_phase(input logic [1:0] ph, output bit seen_ramp);
    seen_ramp = 0;
    for (int i = 0; i < 5000; i++) begin
      if (phase_st == ph) break;
      if (phase_st == 2'd2) seen_ramp = 1;
      @(negedge clk);
    end
  endtask

  task automatic lo_period(output int p);
    int  t0;
    bit  prev;
    prev = gate_lo; t0 = -1; p = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (gate_lo && !prev) begin
        if (t0 < 0) t0 = i;
        else begin p = i - t0; break; end
      end
      prev = gate_lo;
    end
  endtask

  task automatic dead_gap(output int p);
    int  t0;
    bit  prev;
    prev = gate_hi; t0 = -1; p = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (t0 < 0 && prev && !gate_hi) t0 = i;
      if (t0 >= 0 && gate_lo) begin p = i - t0; break; end
      prev = gate_hi;
    end
  endtask

  task automatic hi_width(output int p);
    int  t0;
    bit  prev;
    prev = gate_hi; t0 = -1; p = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (gate_hi && !prev) t0 = i;
      if (t0 >= 0 && prev && !gate_hi) begin p = i - t0; break; end
      prev = gate_hi;
    end
  endtask

  initial begin : stim
    int p;
    int n;
    bit seen;
    cycles(5);
    cur_req = "R1";
    check(!gate_hi && !gate_lo && phase_st == 2'd0, "R1", "held reset state",
          {gate_hi, gate_lo, phase_st}, 0);
    rst_n = 1'b1;
    cycles(10);
    check(phase_st == 2'd0 && !gate_hi && !gate_lo, "R1", "idle without supply",
          phase_st, 0);

    cur_req = "R2";
    supply_lvl = 8'd90;
    cycles(20);
    check(phase_st == 2'd0, "R2", "mid level does not start", phase_st, 0);
    supply_lvl = 8'd110;
    cycles(3);
    check(phase_st == 2'd1, "R2", "start above upper level", phase_st, 1);

    cur_req = "R3";
    lo_period(p);
    check(p == 16, "R3", "heating period clocks", p, 16);
    cur_req = "R6";
    dead_gap(p);
    check(p == DEAD, "R6", "dead gap clocks", p, DEAD);

    cur_req = "R4";
    wait_phase(2'd2, seen);
    check(phase_st == 2'd2, "R4", "ramp phase reached", phase_st, 2);
    cur_req = "R5";
    wait_phase(2'd3, seen);
    check(phase_st == 2'd3, "R5", "run phase reached", phase_st, 3);
    lo_period(p);
    check(p == 32, "R5", "run period clocks", p, 32);
    hi_width(p);
    check(p == 16 - DEAD, "R5", "high-side on time", p, 16 - DEAD);

    cur_req = "R2";
    supply_lvl = 8'd90;
    cycles(30);
    check(phase_st == 2'd3, "R2", "mid level keeps running", phase_st, 3);
    supply_lvl = 8'd70;
    cycles(4);
    check(phase_st == 2'd0 && !gate_hi && !gate_lo, "R2", "stop below lower level",
          phase_st, 0);
    supply_lvl = 8'd110;
    cycles(4);
    check(phase_st == 2'd1, "R2", "restart on valid supply", phase_st, 1);

    cur_req = "R7";
    pulse_fault();
    cycles(3);
    check(phase_st == 2'd0 && !gate_hi && !gate_lo, "R10", "one-clock fault pulse",
          phase_st, 0);
    cycles(100);
    check(phase_st == 2'd0 && !gate_hi && !gate_lo, "R7", "shutdown stays latched",
          phase_st, 0);

    cur_req = "R8";
    pulse_restart();
    cycles(3);
    check(phase_st == 2'd1, "R8", "one-clock restart clears latch (R10)", phase_st, 1);

    cur_req = "R9";
    wait_phase(2'd3, seen);
    pulse_restart();
    wait_phase(2'd1, seen);
    n = 0;
    while (phase_st == 2'd1 && n < 2000) begin n++; @(negedge clk); end
    check(n == 320, "R9", "restart gives full heating length (R3)", n, 320);

    cur_req = "R8";
    pulse_fault();
    cycles(4);
    check(phase_st == 2'd0, "R8", "fault latched before supply cycle", phase_st, 0);
    supply_lvl = 8'd70;
    cycles(4);
    supply_lvl = 8'd110;
    cycles(4);
    check(phase_st == 2'd1, "R8", "supply cycle clears latch", phase_st, 1);

    cur_req = "R12";
    fault_en = 1'b1; restart_en = 1'b1;
    @(negedge clk);
    fault_en = 1'b0; restart_en = 1'b0;
    cycles(6);
    check(phase_st == 2'd0, "R12", "fault wins over restart", phase_st, 0);
    supply_lvl = 8'd70;
    pulse_restart();
    cycles(6);
    check(phase_st == 2'd0, "R12", "low supply wins over restart", phase_st, 0);
    supply_lvl = 8'd110;
    cycles(4);

    cur_req = "R11";
    preheat_len = 16'd40;
    pulse_restart();
    cycles(3);
    inc_pre = 16'd8000;
    preheat_len = 16'd2;
    lo_period(p);
    check(p == 16, "R11", "captured increment unaffected", p, 16);
    cur_req = "R4";
    wait_phase(2'd3, seen);
    check(seen, "R4", "ramp seen for length 40", seen, 1);

    inc_pre = 16'd4096;
    preheat_len = 16'd5;
    pulse_restart();
    cycles(3);
    wait_phase(2'd3, seen);
    check(!seen && phase_st == 2'd3, "R4", "zero-length ramp skipped", seen, 0);

    cur_req = "R3";
    preheat_len = 16'd0;
    pulse_restart();
    wait_phase(2'd1, seen);
    n = 0;
    while (phase_st == 2'd1 && n < 2000) begin n++; @(negedge clk); end
    check(n == 16, "R3", "zero heating length counts as one period", n, 16);
    cycles(50);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule